// File: doc/BRIEF.md
# Bank-switched RAM overlay controller

This block controls a 16 KB RAM expansion that sits over the 12 KB ROM window from $D000 to $FFFF on an 8-bit bus with a per-cycle strobe. A bus access to any of the sixteen switch addresses from $C080 to $C08F updates three pieces of state. The first is whether reads of the upper window come from RAM or from ROM. The second is which of two 4 KB RAM banks appears at $D000-$DFFF. The third is whether RAM writes are allowed. Only bits 3 to 0 of a switch address carry meaning.

For every access to the upper window, the block gives a RAM read select, a ROM read select, a RAM write strobe and a 14-bit RAM offset. Writes are unlocked only by two successive read accesses to odd switch addresses. A write cycle anywhere in the switch range breaks that pairing. An even switch access locks writes again at once. The RAM array, the ROM, slot decoding and auxiliary memory lie outside the block.

Top module: `bank_overlay_ctrl`

## Requirements
- R1: After reset, upper-window reads come from ROM (rom_rd=1, ram_rd=0), bank 2 is selected (ram_addr bit 12 = 0 for $Dxxx) and RAM writes are disabled (ram_we=0). The pre-write count is zero.
- R2: A strobed access whose address bits 15..4 equal $C08 is a switch access. Address bit 3 of every switch access selects the bank: 1 gives bank 1 and 0 gives bank 2. Strobed accesses outside $C080-$C08F change no state.
- R3: After a switch access, upper-window reads come from RAM when its address bits 1 and 0 are equal, and from ROM when they differ. rom_rd and ram_rd are only asserted for read cycles in the window.
- R4: A switch access with address bit 0 clear disables RAM writes starting with the next cycle, and it clears the pre-write count. This holds for reads and writes alike.
- R5: A read switch access with bit 0 set increments the pre-write count, which saturates at 2. If the count was already nonzero, RAM writes become enabled. The two reads may use different odd addresses, so $C081 then $C089 gives ROM reads with writes into bank 1.
- R6: A write cycle to any switch address clears the pre-write count. Read $C08B, write $C08B, read $C08B leaves writes disabled. Write, write, read $C08B also leaves writes disabled.
- R7: A write cycle to an odd switch address leaves the write-enable state unchanged, so two stores to $C081 after enabling keep writes on.
- R8: RAM offset mapping: $Dxxx with bank 2 gives $0xxx, $Dxxx with bank 1 gives $1xxx, and $E000-$FFFF gives $2000-$3FFF regardless of bank.
- R9: ram_we is asserted for a strobed write cycle in $D000-$FFFF exactly when writes are enabled, whatever the read source.
- R10: Cycles without the strobe change no state. A two-read sequence made of a dummy read and a real read of the same odd switch address (two strobed cycles) enables writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Marks a valid bus cycle |
| bus_addr | input | 16 | Bus address |
| bus_rnw | input | 1 | 1 for a read cycle, 0 for a write cycle |
| rom_rd | output | 1 | Read in the upper window is served from ROM |
| ram_rd | output | 1 | Read in the upper window is served from RAM |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 14 | RAM offset for the current upper-window access |

## Verification
The assertions take for granted that the address and read/write inputs are stable and defined while the strobe is high. They also assume that a read-modify-write appears as separate strobed cycles. The stimulus changes inputs only on the falling clock edge and holds the strobe low during reset. Directed sequences reproduce the tricky orderings: mixed odd addresses, a write between two reads, stores after unlocking, and the dummy read of an indexed increment. A long random run mixes switch, window and unrelated addresses, with and without the strobe, and compares against a behavioural model on every cycle.

// File: rtl/bank_overlay_ctrl.sv
module bank_overlay_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_stb,
  input  logic [15:0] bus_addr,
  input  logic        bus_rnw,
  output logic        rom_rd,
  output logic        ram_rd,
  output logic        ram_we,
  output logic [13:0] ram_addr
);

  localparam logic [11:0] SW_PAGE = 12'hC08;
  localparam logic [3:0]  WIN_LO  = 4'hD;

  logic       bank1;
  logic       rd_ram;
  logic       wr_en;
  logic [1:0] pre_cnt;

  logic sw_hit, win_hit, sw_acc;
  assign sw_hit  = bus_addr[15:4] == SW_PAGE;
  assign win_hit = bus_addr[15:12] >= WIN_LO;
  assign sw_acc  = bus_stb && sw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank1   <= 1'b0;
      rd_ram  <= 1'b0;
      wr_en   <= 1'b0;
      pre_cnt <= 2'd0;
    end else if (sw_acc) begin
      bank1  <= bus_addr[3];
      rd_ram <= bus_addr[1] ~^ bus_addr[0];
      if (!bus_addr[0]) begin
        wr_en   <= 1'b0;
        pre_cnt <= 2'd0;
      end else if (bus_rnw) begin
        if (pre_cnt != 2'd0) wr_en <= 1'b1;
        if (pre_cnt != 2'd2) pre_cnt <= pre_cnt + 2'd1;
      end else begin
        pre_cnt <= 2'd0;
      end
    end
  end

  assign rom_rd = win_hit && bus_rnw && !rd_ram;
  assign ram_rd = win_hit && bus_rnw && rd_ram;
  assign ram_we = bus_stb && win_hit && !bus_rnw && wr_en;
  assign ram_addr = (bus_addr[15:12] == WIN_LO) ? {1'b0, bank1, bus_addr[11:0]}
                                                : {1'b1, bus_addr[12:0]};

  // R4
  even_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc && !bus_addr[0] |=> !wr_en && pre_cnt == 2'd0);

  // R6
  sw_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc && !bus_rnw |=> pre_cnt == 2'd0);

  // R5
  we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(sw_acc && bus_rnw && bus_addr[0]));

  // R7
  odd_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc && !bus_rnw && bus_addr[0] |=> wr_en == $past(wr_en));

  // R2
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc |=> bank1 == $past(bus_addr[3]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_acc |=> $stable({bank1, rd_ram, wr_en, pre_cnt}));

  // R9
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !rom_rd && !ram_rd);

endmodule

// File: tb/test_bank_overlay_ctrl.sv
module test_bank_overlay_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_stb = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic bus_rnw = 1'b1;
  logic rom_rd, ram_rd, ram_we;
  logic [13:0] ram_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit m_bank1, m_ram, m_we;
  int m_cnt;

  always #10 clk = ~clk;

  bank_overlay_ctrl i_bank_overlay_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_addr(bus_addr),
    .bus_rnw(bus_rnw), .rom_rd(rom_rd), .ram_rd(ram_rd), .ram_we(ram_we),
    .ram_addr(ram_addr)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bank1 = 0; m_ram = 0; m_we = 0; m_cnt = 0;
  endtask

  task automatic model_step(bit stb, bit rnw, logic [15:0] a);
    if (stb && a[15:4] == 12'hC08) begin
      m_bank1 = a[3];
      m_ram = (a[1] == a[0]);
      if (!a[0]) begin m_we = 0; m_cnt = 0; end
      else if (rnw) begin
        if (m_cnt >= 1) m_we = 1;
        if (m_cnt < 2) m_cnt++;
      end else m_cnt = 0;
    end
  endtask

  function automatic int exp_addr(logic [15:0] a);
    if (a[15:12] == 4'hD) return (m_bank1 ? 32'h1000 : 32'h0000) + int'(a[11:0]);
    return 32'h2000 + int'(a[12:0]);
  endfunction

  task automatic cyc(bit stb, bit rnw, logic [15:0] a);
    bit win;
    @(negedge clk);
    bus_stb = stb; bus_rnw = rnw; bus_addr = a;
    #3;
    win = a[15:12] >= 4'hD;
    chk("R3", "rom_rd", rom_rd, win && rnw && !m_ram);
    chk("R3", "ram_rd", ram_rd, win && rnw && m_ram);
    chk("R9", "ram_we", ram_we, stb && win && !rnw && m_we);
    if (win) chk("R8", "ram_addr", ram_addr, exp_addr(a));
    @(posedge clk);
    model_step(stb, rnw, a);
  endtask

  task automatic probe(string req, bit exp_ram, bit exp_b1, bit exp_we);
    @(negedge clk);
    bus_stb = 1; bus_rnw = 1; bus_addr = 16'hD17B;
    #3;
    chk(req, "probe ram_rd", ram_rd, exp_ram);
    chk(req, "probe rom_rd", rom_rd, !exp_ram);
    chk(req, "probe bank", ram_addr[12], exp_b1);
    bus_rnw = 0;
    #1;
    chk(req, "probe ram_we", ram_we, exp_we);
    @(posedge clk);
  endtask

  task automatic base();
    cyc(1, 1, 16'hC080);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    probe("R1", 0, 0, 0);

    // R2 R3 bank and source from one read
    base(); cyc(1, 1, 16'hC088); probe("R2", 1, 1, 0);
    base(); cyc(1, 1, 16'hC081); probe("R3", 0, 0, 0);
    // R5 mixed odd addresses
    base(); cyc(1, 1, 16'hC081); cyc(1, 1, 16'hC089); probe("R5", 0, 1, 1);
    base(); cyc(1, 1, 16'hC08F); cyc(1, 1, 16'hC087); probe("R5", 1, 0, 1);
    base(); cyc(1, 1, 16'hC087); cyc(1, 1, 16'hC08D); probe("R5", 0, 1, 1);
    // R7 stores after unlock
    base(); cyc(1, 1, 16'hC081); cyc(1, 1, 16'hC081);
    cyc(1, 0, 16'hC081); cyc(1, 0, 16'hC081); probe("R7", 0, 0, 1);
    // R6 write between reads, and two writes then a read
    base(); cyc(1, 1, 16'hC08B); cyc(1, 0, 16'hC08B); cyc(1, 1, 16'hC08B); probe("R6", 1, 1, 0);
    base(); cyc(1, 0, 16'hC08B); cyc(1, 0, 16'hC08B); cyc(1, 1, 16'hC08B); probe("R6", 1, 1, 0);
    // R4 even access locks writes
    base(); cyc(1, 1, 16'hC083); cyc(1, 1, 16'hC083); probe("R4", 1, 0, 1);
    cyc(1, 0, 16'hC08A); probe("R4", 0, 1, 0);
    // R10 dummy read then real read of same odd switch
    base(); cyc(1, 1, 16'hC083); cyc(1, 1, 16'hC083); probe("R10", 1, 0, 1);
    // R10 unstrobed cycles change nothing
    cyc(0, 1, 16'hC088); cyc(0, 1, 16'hC08A); probe("R10", 1, 0, 1);
    // R2 neighbours of switch range change nothing
    cyc(1, 1, 16'hC090); cyc(1, 1, 16'hC07F); cyc(1, 0, 16'hC098); probe("R2", 1, 0, 1);
    // R8 mapping
    cyc(1, 1, 16'hC088);
    @(negedge clk); bus_stb = 1; bus_rnw = 1; bus_addr = 16'hFE1F; #3;
    chk("R8", "FE1F offset", ram_addr, 14'h3E1F);
    bus_addr = 16'hE000; #1; chk("R8", "E000 offset", ram_addr, 14'h2000);
    bus_addr = 16'hD17B; #1; chk("R8", "D17B bank1 offset", ram_addr, 14'h117B);
    @(posedge clk);
    cyc(1, 1, 16'hC080);
    @(negedge clk); bus_addr = 16'hD17B; #3;
    chk("R8", "D17B bank2 offset", ram_addr, 14'h017B);
    @(posedge clk);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] a;
      sel = $urandom_range(0, 9);
      if (sel < 5) a = 16'hC080 | 16'($urandom_range(0, 15));
      else if (sel < 8) a = 16'hD000 + 16'($urandom_range(0, 16'h2FFF));
      else a = 16'($urandom_range(0, 16'hFFFF));
      cyc($urandom_range(0, 9) < 8, $urandom_range(0, 2) != 0, a);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule